// File: doc/BRIEF.md
# Serial Receive Unit with Character FIFO

This block turns an asynchronous serial input into stored characters. An external rate generator supplies a one-cycle enable at sixteen times the bit rate. The receiver uses that enable to find the start bit, check it at mid-bit, and sample each following bit near its centre. The character format is chosen at run time from a few inputs: seven or eight data bits, parity off, even or odd, and one or two stop bits.

Each completed character goes into a first-word-fall-through queue together with three flags: parity error, framing error and break. The consumer reads the head entry from the output pins and advances with a pop strobe. Three sticky or level-based request lines report data, errors and break independently of each other. A ready-to-receive output tells the far end to pause when the queue is close to full. A single clear strobe resets every sticky condition.

Top module: `serial_rx_fifo`

## Requirements
- R1: Data bits arrive least significant bit first. With `cfg_len7_i`=1, seven bits are assembled and stored bit 7 reads 0; otherwise eight bits are assembled.
- R2: With `cfg_par_en_i`=1, one parity bit follows the data. Under `cfg_par_odd_i`=0 the data bits plus parity must hold an even number of ones; under 1, an odd number. A mismatch sets the entry's parity-error flag. With parity off, no parity bit is expected and the flag stays 0.
- R3: The framing-error flag of an entry is 1 when the line is low at the centre of the first stop bit. With `cfg_two_stop_i`=1 the receiver waits one more bit time before it looks for a new start bit, so frames sent back to back with two stop bits are each received correctly.
- R4: An entry whose framing-error flag is set and whose stored data is all zero also carries the break flag. `irq_brk_o` rises and stays high until `clr_i`.
- R5: A falling edge is accepted as a start bit only if the line is still low eight oversample ticks later. A shorter low pulse stores nothing.
- R6: The queue keeps up to DEPTH (16) entries in arrival order. The head entry is on `rd_*` whenever `empty_o`=0. `pop_i` removes it. A pop while empty has no effect.
- R7: A character that completes while the queue is full is discarded and sets `overrun_o`. `overrun_o` stays high until `clr_i`, and the queue contents are unchanged.
- R8: `irq_data_o` is high exactly when the fill level is at least TRIG.
- R9: `irq_err_o` becomes high and sticky after a stored character with a parity or framing error, or after an overrun. `clr_i` clears it together with `irq_brk_o` and `overrun_o`.
- R10: `rts_o` is 1 (far end may send) while the level is below RTS_LIM (14) and 0 at RTS_LIM or more.
- R11: After reset the queue is empty, the level is 0, all request and sticky outputs are 0, and `rts_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick_i | input | 1 | Oversample enable, 16 per bit time |
| rxd_i | input | 1 | Serial line, idle high |
| cfg_len7_i | input | 1 | 1: seven data bits, 0: eight |
| cfg_two_stop_i | input | 1 | 1: two stop bits |
| cfg_par_en_i | input | 1 | 1: parity bit present |
| cfg_par_odd_i | input | 1 | 1: odd parity, 0: even |
| pop_i | input | 1 | Remove head entry |
| clr_i | input | 1 | Clear sticky error, break and overrun |
| rd_data_o | output | 8 | Head entry data |
| rd_perr_o | output | 1 | Head entry parity error |
| rd_ferr_o | output | 1 | Head entry framing error |
| rd_brk_o | output | 1 | Head entry break |
| empty_o | output | 1 | Queue empty |
| level_o | output | $clog2(DEPTH+1) | Number of stored entries |
| irq_data_o | output | 1 | Level at or above TRIG |
| irq_err_o | output | 1 | Sticky receive-error request |
| irq_brk_o | output | 1 | Sticky break request |
| overrun_o | output | 1 | Sticky overrun |
| rts_o | output | 1 | Ready to receive |

## Verification
The bench keeps DEPTH at 16 and RTS_LIM at 14, so a run of seventeen characters reaches the ready-to-receive switch point, fills the queue and then overruns it. TRIG is raised to 4, so the data request has a visible low-to-high point after the fourth character instead of tracking "not empty". The oversample enable fires on every second clock. This means the enable gating and the mid-bit counters are exercised rather than bypassed.

// File: rtl/rx_pkg.sv
package rx_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PAR,
        S_STOP,
        S_STOP2,
        S_HOLD
    } rx_state_e;

    typedef struct packed {
        logic       brk;
        logic       ferr;
        logic       perr;
        logic [7:0] data;
    } rx_entry_t;

endpackage

// File: rtl/rx_framer.sv
module rx_framer
    import rx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick_i,
    input  logic      rxd_i,
    input  logic      len7_i,
    input  logic      two_stop_i,
    input  logic      par_en_i,
    input  logic      par_odd_i,
    output logic      push_o,
    output rx_entry_t entry_o
);
    localparam int CW = $clog2(OSR);
    localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] LAST = CW'(OSR - 1);

    typedef struct packed {
        logic            s1;
        logic            s2;
        rx_state_e       st;
        logic [CW-1:0]   cnt;
        logic [2:0]      bidx;
        logic [7:0]      sh;
        logic            pbit;
        logic            push;
        rx_entry_t       ent;
    } fr_t;

    fr_t  fr_q, fr_d;
    logic line;
    logic at_bit;
    logic bad_stop;

    always_comb begin
        fr_d      = fr_q;
        fr_d.push = 1'b0;
        fr_d.s1   = rxd_i;
        fr_d.s2   = fr_q.s1;
        line      = fr_q.s2;
        at_bit    = (fr_q.cnt == LAST);
        bad_stop  = !line;

        if (fr_q.st == S_HOLD) begin
            // wait for the line to return high after a framing error
            if (line) fr_d.st = S_IDLE;
        end else if (tick_i) begin
            fr_d.cnt = at_bit ? '0 : fr_q.cnt + 1'b1;
            unique case (fr_q.st)
                S_IDLE: begin
                    fr_d.cnt = '0;
                    if (!line) fr_d.st = S_START;
                end
                S_START: begin
                    if (fr_q.cnt == MID) begin
                        fr_d.cnt = '0;
                        if (line) begin
                            fr_d.st = S_IDLE;
                        end else begin
                            fr_d.st   = S_DATA;
                            fr_d.bidx = '0;
                            fr_d.sh   = '0;
                        end
                    end
                end
                S_DATA: begin
                    if (at_bit) begin
                        fr_d.sh[fr_q.bidx] = line;
                        if (fr_q.bidx == (len7_i ? 3'd6 : 3'd7))
                            fr_d.st = par_en_i ? S_PAR : S_STOP;
                        else
                            fr_d.bidx = fr_q.bidx + 3'd1;
                    end
                end
                S_PAR: begin
                    if (at_bit) begin
                        fr_d.pbit = line;
                        fr_d.st   = S_STOP;
                    end
                end
                S_STOP: begin
                    if (at_bit) begin
                        fr_d.push      = 1'b1;
                        fr_d.ent.data  = fr_q.sh;
                        fr_d.ent.perr  = par_en_i &&
                                         ((^fr_q.sh ^ fr_q.pbit) != par_odd_i);
                        fr_d.ent.ferr  = bad_stop;
                        fr_d.ent.brk   = bad_stop && (fr_q.sh == 8'h00);
                        if (bad_stop)        fr_d.st = S_HOLD;
                        else if (two_stop_i) fr_d.st = S_STOP2;
                        else                 fr_d.st = S_IDLE;
                    end
                end
                S_STOP2: begin
                    if (at_bit) fr_d.st = S_IDLE;
                end
                default: fr_d.st = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fr_q      <= '0;
            fr_q.s1   <= 1'b1;
            fr_q.s2   <= 1'b1;
            fr_q.st   <= S_IDLE;
        end else begin
            fr_q <= fr_d;
        end
    end

    assign push_o  = fr_q.push;
    assign entry_o = fr_q.ent;

endmodule

// File: rtl/rx_queue.sv
module rx_queue
    import rx_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  rx_entry_t     din_i,
    input  logic          pop_i,
    output rx_entry_t     head_o,
    output logic [LW-1:0] level_o,
    output logic          empty_o,
    output logic          full_o,
    output logic          drop_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);

    typedef struct packed {
        rx_entry_t [DEPTH-1:0] mem;
        logic [AW-1:0]         wp;
        logic [AW-1:0]         rp;
        logic [LW-1:0]         cnt;
    } q_t;

    q_t   st_q, st_d;
    logic do_push;
    logic do_pop;

    always_comb begin
        st_d    = st_q;
        do_pop  = pop_i && (st_q.cnt != '0);
        do_push = push_i && (st_q.cnt != LW'(DEPTH));
        if (do_push) begin
            st_d.mem[st_q.wp] = din_i;
            st_d.wp = (st_q.wp == TOP) ? '0 : st_q.wp + 1'b1;
        end
        if (do_pop)
            st_d.rp = (st_q.rp == TOP) ? '0 : st_q.rp + 1'b1;
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head_o  = st_q.mem[st_q.rp];
    assign level_o = st_q.cnt;
    assign empty_o = (st_q.cnt == '0);
    assign full_o  = (st_q.cnt == LW'(DEPTH));
    assign drop_o  = push_i && full_o;

endmodule

// File: rtl/rx_status.sv
module rx_status
    import rx_pkg::*;
#(
    parameter int LW      = 5,
    parameter int RTS_LIM = 14,
    parameter int TRIG    = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  rx_entry_t     entry_i,
    input  logic          drop_i,
    input  logic          clr_i,
    input  logic [LW-1:0] level_i,
    output logic          irq_data_o,
    output logic          irq_err_o,
    output logic          irq_brk_o,
    output logic          overrun_o,
    output logic          rts_o
);
    typedef struct packed {
        logic err;
        logic brk;
        logic ovr;
    } sf_t;

    sf_t sf_q, sf_d;

    always_comb begin
        sf_d = sf_q;
        if (clr_i) sf_d = '0;
        // a new event in the same cycle as a clear wins
        if (push_i && (entry_i.perr || entry_i.ferr)) sf_d.err = 1'b1;
        if (push_i && entry_i.brk)                     sf_d.brk = 1'b1;
        if (drop_i) begin
            sf_d.ovr = 1'b1;
            sf_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sf_q <= '0;
        else        sf_q <= sf_d;
    end

    assign irq_err_o  = sf_q.err;
    assign irq_brk_o  = sf_q.brk;
    assign overrun_o  = sf_q.ovr;
    assign irq_data_o = (level_i >= LW'(TRIG));
    assign rts_o      = (level_i < LW'(RTS_LIM));

endmodule

// File: rtl/serial_rx_fifo.sv
module serial_rx_fifo
    import rx_pkg::*;
#(
    parameter int OSR     = 16,
    parameter int DEPTH   = 16,
    parameter int RTS_LIM = 14,
    parameter int TRIG    = 1,
    parameter int LW      = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          os_tick_i,
    input  logic          rxd_i,
    input  logic          cfg_len7_i,
    input  logic          cfg_two_stop_i,
    input  logic          cfg_par_en_i,
    input  logic          cfg_par_odd_i,
    input  logic          pop_i,
    input  logic          clr_i,
    output logic [7:0]    rd_data_o,
    output logic          rd_perr_o,
    output logic          rd_ferr_o,
    output logic          rd_brk_o,
    output logic          empty_o,
    output logic [LW-1:0] level_o,
    output logic          irq_data_o,
    output logic          irq_err_o,
    output logic          irq_brk_o,
    output logic          overrun_o,
    output logic          rts_o
);
    logic      push_w;
    logic      fifo_full_w;
    logic      drop_w;
    rx_entry_t ent_w;
    rx_entry_t head_w;

    rx_framer #(.OSR(OSR)) u_framer (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (os_tick_i),
        .rxd_i      (rxd_i),
        .len7_i     (cfg_len7_i),
        .two_stop_i (cfg_two_stop_i),
        .par_en_i   (cfg_par_en_i),
        .par_odd_i  (cfg_par_odd_i),
        .push_o     (push_w),
        .entry_o    (ent_w)
    );

    rx_queue #(.DEPTH(DEPTH), .LW(LW)) u_queue (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (push_w),
        .din_i   (ent_w),
        .pop_i   (pop_i),
        .head_o  (head_w),
        .level_o (level_o),
        .empty_o (empty_o),
        .full_o  (fifo_full_w),
        .drop_o  (drop_w)
    );

    rx_status #(.LW(LW), .RTS_LIM(RTS_LIM), .TRIG(TRIG)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (push_w),
        .entry_i    (ent_w),
        .drop_i     (drop_w),
        .clr_i      (clr_i),
        .level_i    (level_o),
        .irq_data_o (irq_data_o),
        .irq_err_o  (irq_err_o),
        .irq_brk_o  (irq_brk_o),
        .overrun_o  (overrun_o),
        .rts_o      (rts_o)
    );

    assign rd_data_o = head_w.data;
    assign rd_perr_o = head_w.perr;
    assign rd_ferr_o = head_w.ferr;
    assign rd_brk_o  = head_w.brk;

endmodule

// File: rtl/serial_rx_fifo_chk.sv
module serial_rx_fifo_chk #(
    parameter int DEPTH   = 16,
    parameter int RTS_LIM = 14,
    parameter int LW      = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pop_i,
    input logic          clr_i,
    input logic          empty_o,
    input logic [LW-1:0] level_o,
    input logic          rts_o,
    input logic          overrun_o,
    input logic          irq_brk_o,
    input logic          push_w,
    input logic          fifo_full_w
);
    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level_o <= LW'(DEPTH));

    // R6
    pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty_o && pop_i && !push_w) |=> empty_o);

    // R6
    level_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level_o <= $past(level_o) + LW'(1)));

    // R7
    drop_sets_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_w && fifo_full_w) |=> overrun_o);

    // R7
    ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun_o && !clr_i) |=> overrun_o);

    // R4
    brk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_brk_o && !clr_i) |=> irq_brk_o);

    // R10
    rts_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level_o >= LW'(RTS_LIM)) |-> !rts_o);

endmodule

bind serial_rx_fifo serial_rx_fifo_chk #(
    .DEPTH   (DEPTH),
    .RTS_LIM (RTS_LIM),
    .LW      (LW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pop_i       (pop_i),
    .clr_i       (clr_i),
    .empty_o     (empty_o),
    .level_o     (level_o),
    .rts_o       (rts_o),
    .overrun_o   (overrun_o),
    .irq_brk_o   (irq_brk_o),
    .push_w      (push_w),
    .fifo_full_w (fifo_full_w)
);

// File: tb/sim_serial_rx_fifo.sv
module sim_serial_rx_fifo;
    localparam int DEPTH = 16;
    localparam int RTS   = 14;
    localparam int TRIG  = 4;
    localparam int LW    = $clog2(DEPTH + 1);
    localparam int BIT   = 32;  // 16 ticks, one tick every 2 clocks

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic rxd = 1'b1;
    logic len7 = 1'b0, two_stop = 1'b0, par_en = 1'b0, par_odd = 1'b0;
    logic pop = 1'b0, clr = 1'b0;
    logic [7:0] rd_data;
    logic rd_perr, rd_ferr, rd_brk, empty, irq_data, irq_err, irq_brk, overrun, rts;
    logic [LW-1:0] level;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #2 clk = ~clk;
    always @(negedge clk) tick <= ~tick;

    serial_rx_fifo #(.DEPTH(DEPTH), .RTS_LIM(RTS), .TRIG(TRIG)) u0 (
        .clk(clk), .rst_n(rst_n), .os_tick_i(tick), .rxd_i(rxd),
        .cfg_len7_i(len7), .cfg_two_stop_i(two_stop),
        .cfg_par_en_i(par_en), .cfg_par_odd_i(par_odd),
        .pop_i(pop), .clr_i(clr),
        .rd_data_o(rd_data), .rd_perr_o(rd_perr), .rd_ferr_o(rd_ferr),
        .rd_brk_o(rd_brk), .empty_o(empty), .level_o(level),
        .irq_data_o(irq_data), .irq_err_o(irq_err), .irq_brk_o(irq_brk),
        .overrun_o(overrun), .rts_o(rts)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic hold_bit(input logic v);
        rxd = v;
        repeat (BIT) @(negedge clk);
    endtask

    // stop1 is the level driven during the first stop bit; bad_par flips parity
    task automatic send(input logic [7:0] d, input logic stop1, input logic bad_par);
        int n;
        logic p;
        logic [7:0] m;
        n = len7 ? 7 : 8;
        m = len7 ? {1'b0, d[6:0]} : d;
        p = (^m) ^ par_odd ^ bad_par;
        hold_bit(1'b0);
        for (int i = 0; i < n; i++) hold_bit(d[i]);
        if (par_en) hold_bit(p);
        hold_bit(stop1);
        if (two_stop) hold_bit(1'b1);
        hold_bit(1'b1);
        hold_bit(1'b1);
    endtask

    task automatic pop_chk(input string tag, input logic [7:0] d,
                           input logic pe, input logic fe, input logic bk);
        @(negedge clk);
        chk({tag, " empty"}, empty, 0);
        chk({tag, " data"}, rd_data, d);
        chk({tag, " perr"}, rd_perr, pe);
        chk({tag, " ferr"}, rd_ferr, fe);
        chk({tag, " brk"}, rd_brk, bk);
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R11 level", level, 0);
        chk("R11 empty", empty, 1);
        chk("R11 rts", rts, 1);
        chk("R11 irqs", {irq_data, irq_err, irq_brk, overrun}, 0);
    endtask

    task automatic t_eight_bit();
        len7 = 0; par_en = 0; two_stop = 0;
        send(8'hA5, 1, 0);
        send(8'h3C, 1, 0);
        chk("R1 level", level, 2);
        pop_chk("R1 first", 8'hA5, 0, 0, 0);
        pop_chk("R1 second", 8'h3C, 0, 0, 0);
        chk("R1 irq_err", irq_err, 0);
    endtask

    task automatic t_seven_bit();
        len7 = 1; par_en = 1; par_odd = 0;
        send(8'hFF, 1, 0);
        pop_chk("R1 len7 top bit zero", 8'h7F, 0, 0, 0);
        send(8'h55, 1, 0);
        pop_chk("R2 len7 even ok", 8'h55, 0, 0, 0);
        len7 = 0; par_en = 0;
    endtask

    task automatic t_parity();
        par_en = 1; par_odd = 1;
        send(8'h96, 1, 0);
        pop_chk("R2 odd ok", 8'h96, 0, 0, 0);
        chk("R9 no err", irq_err, 0);
        send(8'h96, 1, 1);
        pop_chk("R2 odd bad", 8'h96, 1, 0, 0);
        chk("R9 err set", irq_err, 1);
        pulse_clr();
        chk("R9 err cleared", irq_err, 0);
        par_odd = 0;
        send(8'h01, 1, 1);
        pop_chk("R2 even bad", 8'h01, 1, 0, 0);
        pulse_clr();
        par_en = 0;
    endtask

    task automatic t_stop();
        two_stop = 1;
        send(8'h81, 1, 0);
        send(8'h42, 1, 0);
        pop_chk("R3 two stop a", 8'h81, 0, 0, 0);
        pop_chk("R3 two stop b", 8'h42, 0, 0, 0);
        two_stop = 0;
        send(8'h18, 0, 0);
        pop_chk("R3 framing", 8'h18, 0, 1, 0);
        chk("R3 err req", irq_err, 1);
        chk("R4 no break", irq_brk, 0);
        pulse_clr();
    endtask

    task automatic t_break();
        send(8'h00, 0, 0);
        chk("R4 brk req", irq_brk, 1);
        pop_chk("R4 break entry", 8'h00, 0, 1, 1);
        repeat (5) @(negedge clk);
        chk("R4 brk sticky", irq_brk, 1);
        pulse_clr();
        chk("R4 brk cleared", irq_brk, 0);
        chk("R9 clr err", irq_err, 0);
    endtask

    task automatic t_glitch();
        rxd = 1'b0;
        repeat (8) @(negedge clk);
        rxd = 1'b1;
        repeat (3 * BIT) @(negedge clk);
        chk("R5 glitch stored nothing", level, 0);
        send(8'h5A, 1, 0);
        pop_chk("R5 after glitch", 8'h5A, 0, 0, 0);
    endtask

    task automatic t_fill();
        for (int i = 1; i <= 17; i++) begin
            send(8'h20 + 8'(i), 1, 0);
            if (i == 3)  chk("R8 below trig", irq_data, 0);
            if (i == 4)  chk("R8 at trig", irq_data, 1);
            if (i == 13) chk("R10 rts on", rts, 1);
            if (i == 14) chk("R10 rts off", rts, 0);
            if (i == 16) chk("R7 no ovr yet", overrun, 0);
        end
        chk("R7 overrun", overrun, 1);
        chk("R7 level full", level, DEPTH);
        chk("R9 ovr err", irq_err, 1);
        for (int i = 1; i <= 16; i++)
            pop_chk("R6 order", 8'h20 + 8'(i), 0, 0, 0);
        chk("R6 empty", empty, 1);
        chk("R7 ovr sticky", overrun, 1);
        @(negedge clk);
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
        chk("R6 pop empty level", level, 0);
        send(8'hC3, 1, 0);
        chk("R6 level one", level, 1);
        pop_chk("R6 after empty pop", 8'hC3, 0, 0, 0);
        pulse_clr();
        chk("R7 ovr cleared", overrun, 0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            bad++;
            total++;
            $display("FAIL watchdog R6 actual=%0d expected=done", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_eight_bit();
        t_seven_bit();
        t_parity();
        t_stop();
        t_break();
        t_glitch();
        t_fill();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule